// File: doc/BRIEF.md
# Debug Target Soft-Reset Sequencer

This controller makes a debug target restart itself over the serial-wire debug port. A single start pulse launches a fixed script of six transactions. The script first clears the sticky error flags in the debug port and selects access-port bank zero. It then sets the access port for 32-bit accesses and points it at the target's reset control register. Next it writes the key together with the reset-request bits to that register. Last, it reads the debug-port read buffer so that the posted write is pushed through.

Every transaction goes to a separate transfer engine, which owns the pin timing, through a request/done handshake. The sequencer holds the request code and the write word steady until the engine strobes done with an acknowledge code. It records that code and moves on to the next step. The sequencer never retries. It always runs to the end of the script, then pulses done with the final acknowledge and a sticky error flag. The flag also carries the index of a failing step.

Top module: `soft_reset_seq`

## Requirements
- R1: After reset, req_valid_o, busy_o, seq_done_o and seq_err_o are 0, and last_ack_o and err_step_o are 0.
- R2: A start_i pulse while idle raises busy_o and req_valid_o on the next clock, presenting the first request (code 0x0, write word 0x0000001E).
- R3: The requests are issued in this exact order as {code, write word}: {0x0, 0x0000001E}, {0x8, 0x00000000}, {0x1, 0x23000012}, {0x5, 0xE000ED0C}, {0xD, 0x05FA0007}, {0xE, 0x00000000}. req_wdata_o[7:0] is the least significant byte, so byte 0 of step five is 0x07 and byte 3 is 0x05.
- R4: While req_valid_o is high and xfer_done_i is low, req_code_o and req_wdata_o stay unchanged. A request is consumed only on a cycle with xfer_done_i high.
- R5: On the clock after the sixth done strobe, seq_done_o is high for exactly one cycle and req_valid_o is low. At that point last_ack_o equals the acknowledge of the sixth step. busy_o falls on the following clock.
- R6: An acknowledge other than OK (3'b001) on any step sets seq_err_o, which stays set until the next start. The sequence still issues all six requests.
- R7: err_step_o gives the 0-based step index of the first non-OK acknowledge in the run when ERR_FIRST=1 (the default), or of the last one when ERR_FIRST=0.
- R8: A start_i pulse while busy_o is high has no effect: exactly six requests are issued in order, and no new request follows the done pulse.
- R9: A start from idle clears seq_err_o, err_step_o and last_ack_o before the new run records anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the reset script (sampled when idle) |
| req_valid_o | output | 1 | Request presented to the transfer engine |
| req_code_o | output | REQ_W | Request code: bit0 port select, bit1 read, bits3:2 register address |
| req_wdata_o | output | DATA_W | Write word; bits 7:0 are the least significant byte |
| xfer_done_i | input | 1 | Engine strobe: current request finished |
| xfer_ack_i | input | ACK_W | Acknowledge code of the finished request |
| busy_o | output | 1 | Script in progress |
| seq_done_o | output | 1 | One-cycle pulse at the end of the script |
| last_ack_o | output | ACK_W | Acknowledge of the most recent step |
| seq_err_o | output | 1 | Sticky: some step did not acknowledge OK |
| err_step_o | output | 3 | Index of the reported failing step |

## Verification
The assertions assume that the engine raises xfer_done_i only while req_valid_o is high, and only for a single cycle per request. They also assume that xfer_ack_i is valid whenever xfer_done_i is high. The bench engine model follows this contract. It waits for req_valid_o and for a per-step latency, which may be zero. It then drives done with the step's acknowledge for one cycle and drops it before the next request is examined. Start pulses are issued both from idle and in the middle of a run.

// File: rtl/srs_pkg.sv
package srs_pkg;
   localparam int STEP_CNT   = 6;
   localparam int STEP_IDX_W = 3;
   localparam int CODE_W     = 4;
   localparam int WORD_W     = 32;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [WORD_W-1:0] word;
   } step_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_t;

   // Script: clear sticky flags, bank 0, 32-bit access, reset-control address,
   // key plus reset request, then read-buffer flush.
   function automatic step_t step_at(input logic [STEP_IDX_W-1:0] idx);
      step_t s;
      case (idx)
         3'd0:    s = '{code: 4'h0, word: 32'h0000_001E};
         3'd1:    s = '{code: 4'h8, word: 32'h0000_0000};
         3'd2:    s = '{code: 4'h1, word: 32'h2300_0012};
         3'd3:    s = '{code: 4'h5, word: 32'hE000_ED0C};
         3'd4:    s = '{code: 4'hD, word: 32'h05FA_0007};
         3'd5:    s = '{code: 4'hE, word: 32'h0000_0000};
         default: s = '{code: 4'h0, word: 32'h0000_0000};
      endcase
      return s;
   endfunction
endpackage

// File: rtl/srs_step_rom.sv
module srs_step_rom
   import srs_pkg::*;
#(
   parameter int REQ_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic [STEP_IDX_W-1:0] idx_i,
   output logic [REQ_W-1:0]      code_o,
   output logic [DATA_W-1:0]     word_o
);
   localparam int FULL_W = CODE_W + WORD_W;

   generate
      if (REQ_W != CODE_W) begin : g_bad_req_w
         $error("srs_step_rom: REQ_W must be %0d", CODE_W);
      end
      if (DATA_W != WORD_W) begin : g_bad_data_w
         $error("srs_step_rom: DATA_W must be %0d", WORD_W);
      end
   endgenerate

   logic [FULL_W-1:0] entry;

   always_comb begin
      entry  = step_at(idx_i);
      code_o = entry[FULL_W-1 -: REQ_W];
      word_o = entry[DATA_W-1:0];
   end
endmodule

// File: rtl/srs_ack_tracker.sv
module srs_ack_tracker
   import srs_pkg::*;
#(
   parameter int               ACK_W     = 3,
   parameter logic [ACK_W-1:0] ACK_OK    = 3'b001,
   parameter bit               ERR_FIRST = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic                  rec_i,
   input  logic [ACK_W-1:0]      ack_i,
   input  logic [STEP_IDX_W-1:0] idx_i,
   output logic [ACK_W-1:0]      last_ack_o,
   output logic                  err_o,
   output logic [STEP_IDX_W-1:0] err_idx_o
);
   logic bad_ack;
   logic take_idx;

   assign bad_ack = (ack_i != ACK_OK);

   generate
      if (ERR_FIRST) begin : g_first
         assign take_idx = rec_i && bad_ack && !err_o;
      end else begin : g_last
         assign take_idx = rec_i && bad_ack;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_ack_o <= '0;
         err_o      <= 1'b0;
         err_idx_o  <= '0;
      end else if (clr_i) begin
         last_ack_o <= '0;
         err_o      <= 1'b0;
         err_idx_o  <= '0;
      end else begin
         if (rec_i) last_ack_o <= ack_i;
         if (rec_i && bad_ack) err_o <= 1'b1;
         if (take_idx) err_idx_o <= idx_i;
      end
   end

   p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o && !clr_i |=> err_o);
   p_bad_ack_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_i && bad_ack && !clr_i |=> err_o && (last_ack_o == $past(ack_i)));
   p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !err_o && (err_idx_o == '0) && (last_ack_o == '0));
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq
   import srs_pkg::*;
#(
   parameter int               REQ_W     = 4,
   parameter int               DATA_W    = 32,
   parameter int               ACK_W     = 3,
   parameter logic [ACK_W-1:0] ACK_OK    = 3'b001,
   parameter bit               ERR_FIRST = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   output logic                  req_valid_o,
   output logic [REQ_W-1:0]      req_code_o,
   output logic [DATA_W-1:0]     req_wdata_o,
   input  logic                  xfer_done_i,
   input  logic [ACK_W-1:0]      xfer_ack_i,
   output logic                  busy_o,
   output logic                  seq_done_o,
   output logic [ACK_W-1:0]      last_ack_o,
   output logic                  seq_err_o,
   output logic [STEP_IDX_W-1:0] err_step_o
);
   localparam logic [STEP_IDX_W-1:0] LAST_IDX = STEP_IDX_W'(STEP_CNT - 1);

   generate
      if (ACK_W < 1) begin : g_bad_ack_w
         $error("soft_reset_seq: ACK_W must be at least 1");
      end
   endgenerate

   seq_state_t            st_q;
   logic [STEP_IDX_W-1:0] idx_q;
   logic                  launch;
   logic                  consume;

   assign launch  = (st_q == ST_IDLE) && start_i;
   assign consume = (st_q == ST_RUN) && xfer_done_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) begin
               st_q  <= ST_RUN;
               idx_q <= '0;
            end
            ST_RUN: if (xfer_done_i) begin
               if (idx_q == LAST_IDX) st_q <= ST_FIN;
               else                   idx_q <= idx_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   srs_step_rom #(.REQ_W(REQ_W), .DATA_W(DATA_W)) i_rom (
      .idx_i  (idx_q),
      .code_o (req_code_o),
      .word_o (req_wdata_o)
   );

   srs_ack_tracker #(.ACK_W(ACK_W), .ACK_OK(ACK_OK), .ERR_FIRST(ERR_FIRST)) i_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (launch),
      .rec_i      (consume),
      .ack_i      (xfer_ack_i),
      .idx_i      (idx_q),
      .last_ack_o (last_ack_o),
      .err_o      (seq_err_o),
      .err_idx_o  (err_step_o)
   );

   assign req_valid_o = (st_q == ST_RUN);
   assign busy_o      = (st_q != ST_IDLE);
   assign seq_done_o  = (st_q == ST_FIN);

   p_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && start_i |=> req_valid_o && (req_code_o == '0));
   p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o && !xfer_done_i |=> req_valid_o && $stable(req_code_o) && $stable(req_wdata_o));
   p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_done_o |=> !seq_done_o && !busy_o);
   p_done_follows_engine_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(seq_done_o) |-> $past(xfer_done_i) && !req_valid_o);
   p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o && start_i && !xfer_done_i |=> req_valid_o && $stable(req_code_o));
endmodule

// File: tb/test_soft_reset_seq.sv
module test_soft_reset_seq;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [3:0]  code;
      logic [31:0] word;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_valid;
   logic [3:0]  req_code;
   logic [31:0] req_wdata;
   logic        xfer_done = 1'b0;
   logic [2:0]  xfer_ack = 3'b000;
   logic        busy;
   logic        seq_done;
   logic [2:0]  last_ack;
   logic        seq_err;
   logic [2:0]  err_step;

   int   n_checks = 0;
   int   n_fail = 0;
   int   req_cnt = 0;
   exp_t exp_q[$];
   logic [2:0] ack_tbl [6];
   int         lat_tbl [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   soft_reset_seq i_soft_reset_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .req_valid_o(req_valid), .req_code_o(req_code), .req_wdata_o(req_wdata),
      .xfer_done_i(xfer_done), .xfer_ack_i(xfer_ack),
      .busy_o(busy), .seq_done_o(seq_done), .last_ack_o(last_ack),
      .seq_err_o(seq_err), .err_step_o(err_step)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Driver: queue the script (R3) and pulse start from idle.
   task automatic launch();
      exp_q.push_back('{4'h0, 32'h0000_001E});
      exp_q.push_back('{4'h8, 32'h0000_0000});
      exp_q.push_back('{4'h1, 32'h2300_0012});
      exp_q.push_back('{4'h5, 32'hE000_ED0C});
      exp_q.push_back('{4'hD, 32'h05FA_0007});
      exp_q.push_back('{4'hE, 32'h0000_0000});
      req_cnt = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(req_valid && busy && req_code == 4'h0, "R2 launch", {27'b0, req_valid, req_code}, {27'b0, 1'b1, 4'h0});
   endtask

   // Engine model plus monitor: pops the scoreboard on each request.
   initial begin
      forever begin
         @(negedge clk);
         while (req_valid) begin
            exp_t e;
            int   k;
            k = req_cnt;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected request", {28'b0, req_code}, 32'h0);
            end else begin
               e = exp_q.pop_front();
               check(req_code == e.code, "R3 code", {28'b0, req_code}, {28'b0, e.code});
               check(req_wdata == e.word, "R3 word", req_wdata, e.word);
            end
            if (k == 4) check(req_wdata[7:0] == 8'h07 && req_wdata[31:24] == 8'h05, "R3 byte order", req_wdata, 32'h05FA_0007);
            for (int i = 0; i < lat_tbl[k % 6]; i++) begin
               @(negedge clk);
               check(req_valid && req_code == e.code && req_wdata == e.word, "R4 hold", req_wdata, e.word);
            end
            xfer_done = 1'b1;
            xfer_ack  = ack_tbl[k % 6];
            req_cnt++;
            @(negedge clk);
            xfer_done = 1'b0;
            xfer_ack  = 3'b000;
         end
      end
   end

   // Waits for the done pulse, then checks the result against the ack table.
   task automatic expect_end(input logic [2:0] exp_last, input bit exp_err, input logic [2:0] exp_step);
      int t;
      t = 0;
      while (!seq_done && t < 200) begin
         @(negedge clk);
         t++;
      end
      check(seq_done && !req_valid, "R5 done pulse", {31'b0, seq_done}, 32'h1);
      check(last_ack == exp_last, "R5 last ack", {29'b0, last_ack}, {29'b0, exp_last});
      check(seq_err == exp_err, "R6 error flag", {31'b0, seq_err}, {31'b0, exp_err});
      check(req_cnt == 6, "R6 all steps issued", req_cnt, 6);
      if (exp_err) check(err_step == exp_step, "R7 err step", {29'b0, err_step}, {29'b0, exp_step});
      @(negedge clk);
      check(!seq_done && !busy, "R5 single pulse", {30'b0, seq_done, busy}, 32'h0);
      repeat (4) @(negedge clk);
      check(!req_valid && req_cnt == 6 && exp_q.size() == 0, "R8 no extra request", req_cnt, 6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      ack_tbl = '{3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001};
      lat_tbl = '{3, 0, 1, 2, 0, 4};
      repeat (3) @(negedge clk);
      check(!req_valid && !busy && !seq_done && !seq_err && last_ack == 3'b0 && err_step == 3'b0,
            "R1 reset state", {26'b0, req_valid, busy, seq_done, seq_err, 2'b0}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Run A: all OK, start pulsed again mid-run (R8).
      launch();
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      expect_end(3'b001, 1'b0, 3'b000);

      // Run B: WAIT on step 2, FAULT on step 4; first failure index reported (R7).
      ack_tbl = '{3'b001, 3'b001, 3'b010, 3'b001, 3'b100, 3'b001};
      lat_tbl = '{0, 2, 1, 0, 3, 1};
      launch();
      expect_end(3'b001, 1'b1, 3'b010);

      // Run C: only the flush fails; start must clear previous error (R9).
      ack_tbl = '{3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b111};
      lat_tbl = '{2, 2, 2, 2, 2, 2};
      launch();
      check(!seq_err && err_step == 3'b0 && last_ack == 3'b0, "R9 cleared on start",
            {27'b0, seq_err, err_step, 1'b0}, 32'h0);
      expect_end(3'b111, 1'b1, 3'b101);

      finish_run();
   end
endmodule